// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Alarm

This block keeps wall-clock time and a calendar date. It advances from a one-second enable strobe supplied by the surrounding chip. The fields are seconds, minutes, hours, day of month, month, a two-digit year counted from 2000, and a free-running weekday. Software reaches every field through a small bank of byte registers in BCD form. Hours are held as 0 to 23 inside the block; in 12-hour mode they are read and written with an AM/PM flag.

A separate alarm set holds a date and time in BCD. When the alarm is enabled and the clock reaches that moment, the block raises an alarm event. A periodic tick event fires every second, minute, hour or day, as selected. Two conditions raise an error event: a malformed BCD write and an out-of-range field write. The three event outputs are single-cycle pulses meant for an interrupt collector.

Slow crystal drift is corrected by a signed 16-bit word. The word is added once per counted hour, in units of 1/32768 s, into an accumulator. Each time the accumulator passes a whole second, the block either drops one strobe or inserts one extra step.

Top module: `bcd_rtc`

## Requirements
- R1: After reset, reads return the following: control 0x00; time 00:00:00 on day 0x01, month 0x01, year 0x00, weekday 0x00; alarm 00:00:00 on day 0x01, month 0x01, year 0x04; compensation 0x00/0x00. All event outputs are low.
- R2: The register map is as follows:
  - 0x00 control
  - 0x01 to 0x07: seconds, minutes, hours, day, month, year, weekday
  - 0x08 to 0x0D: alarm seconds, minutes, hours, day, month, year
  - 0x0E: compensation high byte
  - 0x0F: compensation low byte
  
  Control keeps only bits 4:0: bit 0 run, bit 1 alarm enable, bit 2 12-hour mode, bits 4:3 tick select. Bits 7:5 read back as 0.
- R3: Each `sec_pulse` taken while run is 1 advances the time by one second, and the events for that second are registered on the same edge. While run is 0, pulses change nothing.
- R4: Rollover rules:
  - Seconds, minutes and hours carry normally.
  - The day returns to 1 after the last day of the month: 30-day months, 31-day months, February 28, or February 29 when the year is divisible by 4.
  - Month 12 rolls to 1 and increments the year; year 99 rolls to 0.
  - The weekday steps on each day change and wraps from 6 to 0.
- R5: Tick select picks when `evt_tick` fires, judged on the time just reached:
  - 0: every second
  - 1: when seconds are 0
  - 2: when seconds and minutes are 0
  - 3: when seconds, minutes and hours are all 0
- R6: With control bit 2 set, time and alarm hour reads return BCD((hour mod 12)+1), with bit 7 set when the stored hour is 12 or more. With bit 2 clear, they return the plain BCD hour.
- R7: Hour writes in 12-hour mode decode n = min(BCD(value[5:0]), 12) and store n+11 when bit 7 is set, or n−1 when bit 7 is clear. In 24-hour mode, value[5:0] is taken as BCD 0 to 23.
- R8: Field masking and encoding:
  - Seconds and minutes writes use only bits 6:0.
  - Day and hour writes use bits 5:0.
  - Month writes use bits 4:0, and a written month of 0 becomes 1.
  - Month reads are BCD 1 to 12; year reads are BCD of year−2000.
- R9: `evt_alarm` pulses on a step when alarm enable is set and the new seconds, minutes, hours, day, month and year all equal the alarm fields.
- R10: A time or alarm write is rejected when any of the following holds:
  - a BCD digit above 9
  - seconds or minutes of 60 or more
  - an hour above 23, or a 12-hour value of 0 with bit 7 clear
  - day 0 or a day above 31
  - a month above 12
  - a weekday above 6
  
  A rejected write leaves the field unchanged and pulses `evt_err` on the write edge.
- R11: Compensation timing and effect:
  - The first adjustment falls on the 1800th counted second after reset, and every 3600 counted seconds after that.
  - Each adjustment adds the signed compensation word to an accumulator.
  - When the accumulator reaches −32768 or below, the current pulse does not advance the time and 32768 is added back.
  - When it reaches 32768 or above, one extra step occurs on the following cycle and 32768 is subtracted.
- R12: `rd_data` presents the addressed register one cycle after `rd_en`. Unmapped addresses 0x10 to 0x1F read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_pulse | input | 1 | One-cycle strobe per elapsed second |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| evt_tick | output | 1 | Periodic tick event pulse |
| evt_alarm | output | 1 | Alarm match event pulse |
| evt_err | output | 1 | Rejected write event pulse |

## Verification
The assertions check the following on every cycle:
- every stored field stays within its legal range
- the time never moves without a step or a write
- a minute or day tick only ever fires on a zero boundary
- an alarm pulse always coincides with an exact match against the alarm set
- an error pulse always follows a write

Some behaviour only the directed scenarios can show. These are the leap and month-length rollovers, the 12-hour encode and decode round trips, the field masking, and the compensation outcome after thousands of seconds, where a whole second is dropped or inserted.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] RA_CTRL    = 5'h00;
  localparam logic [ADDR_W-1:0] RA_SEC     = 5'h01;
  localparam logic [ADDR_W-1:0] RA_MIN     = 5'h02;
  localparam logic [ADDR_W-1:0] RA_HOUR    = 5'h03;
  localparam logic [ADDR_W-1:0] RA_DAY     = 5'h04;
  localparam logic [ADDR_W-1:0] RA_MON     = 5'h05;
  localparam logic [ADDR_W-1:0] RA_YEAR    = 5'h06;
  localparam logic [ADDR_W-1:0] RA_WDAY    = 5'h07;
  localparam logic [ADDR_W-1:0] RA_ASEC    = 5'h08;
  localparam logic [ADDR_W-1:0] RA_AMIN    = 5'h09;
  localparam logic [ADDR_W-1:0] RA_AHOUR   = 5'h0A;
  localparam logic [ADDR_W-1:0] RA_ADAY    = 5'h0B;
  localparam logic [ADDR_W-1:0] RA_AMON    = 5'h0C;
  localparam logic [ADDR_W-1:0] RA_AYEAR   = 5'h0D;
  localparam logic [ADDR_W-1:0] RA_COMP_HI = 5'h0E;
  localparam logic [ADDR_W-1:0] RA_COMP_LO = 5'h0F;

  typedef enum logic [2:0] {
    F_SEC, F_MIN, F_HOUR, F_DAY, F_MON, F_YEAR, F_WDAY, F_NONE
  } field_e;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [4:0] day;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } rtc_time_t;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [4:0] day;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } rtc_alarm_t;

  function automatic field_e field_of(input logic [ADDR_W-1:0] a);
    case (a)
      RA_SEC,  RA_ASEC:  return F_SEC;
      RA_MIN,  RA_AMIN:  return F_MIN;
      RA_HOUR, RA_AHOUR: return F_HOUR;
      RA_DAY,  RA_ADAY:  return F_DAY;
      RA_MON,  RA_AMON:  return F_MON;
      RA_YEAR, RA_AYEAR: return F_YEAR;
      RA_WDAY:           return F_WDAY;
      default:           return F_NONE;
    endcase
  endfunction

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v - tens * 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic bcd_ok(input logic [7:0] b);
    return (b[7:4] < 4'd10) && (b[3:0] < 4'd10);
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
    case (m)
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      4'd2:                    return leap ? 5'd29 : 5'd28;
      default:                 return 5'd31;
    endcase
  endfunction

  function automatic logic [7:0] hour_to_reg(input logic [4:0] h, input logic m12);
    logic [6:0] shown;
    if (!m12) return to_bcd(7'(h));
    shown = (h >= 5'd12) ? 7'(h) - 7'd11 : 7'(h) + 7'd1;
    return to_bcd(shown) | ((h >= 5'd12) ? 8'h80 : 8'h00);
  endfunction

endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
  import bcd_rtc_pkg::*;
(
  input  rtc_time_t cur,
  output rtc_time_t nxt
);

  logic       leap;
  logic [4:0] last_day;

  assign leap     = (cur.year[1:0] == 2'b00);
  assign last_day = month_len(cur.mon, leap);

  always_comb begin
    nxt = cur;
    if (cur.sec != 6'd59) begin
      nxt.sec = cur.sec + 6'd1;
    end else begin
      nxt.sec = 6'd0;
      if (cur.min != 6'd59) begin
        nxt.min = cur.min + 6'd1;
      end else begin
        nxt.min = 6'd0;
        if (cur.hour != 5'd23) begin
          nxt.hour = cur.hour + 5'd1;
        end else begin
          nxt.hour = 5'd0;
          nxt.wday = (cur.wday >= 3'd6) ? 3'd0 : cur.wday + 3'd1;
          if (cur.day < last_day) begin
            nxt.day = cur.day + 5'd1;
          end else begin
            nxt.day = 5'd1;
            if (cur.mon < 4'd12) begin
              nxt.mon = cur.mon + 4'd1;
            end else begin
              nxt.mon  = 4'd1;
              nxt.year = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/rtc_drift_comp.sv
module rtc_drift_comp #(
  parameter int COMP_W = 16,
  parameter int PERIOD = 3600,
  parameter int FIRST  = 1800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_in,
  input  logic [COMP_W-1:0] comp,
  output logic              step
);

  localparam int CNT_MAX = (PERIOD > FIRST) ? PERIOD : FIRST;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int ACC_W   = COMP_W + 2;
  localparam logic signed [ACC_W-1:0] ONE  = ACC_W'(2 ** (COMP_W - 1));
  localparam logic signed [ACC_W-1:0] MONE = -ONE;

  logic [CNT_W-1:0]        cnt_q;
  logic signed [ACC_W-1:0] acc_q, acc_n, sum;
  logic                    extra_q, due, skip, ins;

  always_comb begin
    due   = sec_in && (cnt_q == CNT_W'(1));
    sum   = acc_q + $signed({{2{comp[COMP_W-1]}}, comp});
    skip  = 1'b0;
    ins   = 1'b0;
    acc_n = acc_q;
    if (due) begin
      if (sum >= ONE) begin
        ins   = 1'b1;
        acc_n = sum - ONE;
      end else if (sum <= MONE) begin
        skip  = 1'b1;
        acc_n = sum + ONE;
      end else begin
        acc_n = sum;
      end
    end
    step = (sec_in && !skip) || extra_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= CNT_W'(FIRST);
      acc_q   <= '0;
      extra_q <= 1'b0;
    end else begin
      if (sec_in) cnt_q <= due ? CNT_W'(PERIOD) : cnt_q - CNT_W'(1);
      acc_q   <= acc_n;
      extra_q <= ins || (extra_q && sec_in && !skip);
    end
  end

endmodule

// File: rtl/rtc_wr_decode.sv
module rtc_wr_decode
  import bcd_rtc_pkg::*;
(
  input  field_e     field,
  input  logic       mode12,
  input  logic [7:0] wdata,
  output logic [6:0] value,
  output logic       bad
);

  logic [7:0] b;
  logic [6:0] v;
  logic [6:0] h12;

  always_comb begin
    case (field)
      F_SEC, F_MIN:   b = {1'b0, wdata[6:0]};
      F_HOUR, F_DAY:  b = {2'b00, wdata[5:0]};
      F_MON:          b = {3'b000, wdata[4:0]};
      F_WDAY:         b = {5'b00000, wdata[2:0]};
      default:        b = wdata;
    endcase
    v     = from_bcd(b);
    h12   = (v > 7'd12) ? 7'd12 : v;
    value = v;
    bad   = !bcd_ok(b);
    case (field)
      F_SEC, F_MIN: if (v >= 7'd60) bad = 1'b1;
      F_HOUR: begin
        if (mode12) begin
          if (wdata[7])          value = h12 + 7'd11;
          else if (h12 == 7'd0)  bad   = 1'b1;
          else                   value = h12 - 7'd1;
        end else if (v > 7'd23) begin
          bad = 1'b1;
        end
      end
      F_DAY:  if (v == 7'd0 || v > 7'd31) bad = 1'b1;
      F_MON: begin
        if (v == 7'd0) value = 7'd1;
        if (v > 7'd12) bad = 1'b1;
      end
      F_WDAY: if (v > 7'd6) bad = 1'b1;
      F_YEAR: ;
      default: begin
        value = 7'd0;
        bad   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
  import bcd_rtc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [4:0]        ctrl,
  input  rtc_time_t         cur,
  input  rtc_alarm_t        alm,
  input  logic [15:0]       comp,
  output logic [7:0]        data
);

  always_comb begin
    case (addr)
      RA_CTRL:    data = {3'b000, ctrl};
      RA_SEC:     data = to_bcd(7'(cur.sec));
      RA_MIN:     data = to_bcd(7'(cur.min));
      RA_HOUR:    data = hour_to_reg(cur.hour, ctrl[2]);
      RA_DAY:     data = to_bcd(7'(cur.day));
      RA_MON:     data = to_bcd(7'(cur.mon));
      RA_YEAR:    data = to_bcd(cur.year);
      RA_WDAY:    data = to_bcd(7'(cur.wday));
      RA_ASEC:    data = to_bcd(7'(alm.sec));
      RA_AMIN:    data = to_bcd(7'(alm.min));
      RA_AHOUR:   data = hour_to_reg(alm.hour, ctrl[2]);
      RA_ADAY:    data = to_bcd(7'(alm.day));
      RA_AMON:    data = to_bcd(7'(alm.mon));
      RA_AYEAR:   data = to_bcd(alm.year);
      RA_COMP_HI: data = comp[15:8];
      RA_COMP_LO: data = comp[7:0];
      default:    data = 8'h00;
    endcase
  end

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import bcd_rtc_pkg::*;
#(
  parameter int COMP_PERIOD = 3600,
  parameter int COMP_FIRST  = 1800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_pulse,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rd_data,
  output logic              evt_tick,
  output logic              evt_alarm,
  output logic              evt_err
);

  localparam int COMP_W = 16;

  logic [4:0]        ctrl_q;
  logic [COMP_W-1:0] comp_q;
  rtc_time_t         cur_q, step_t, nxt_t;
  rtc_alarm_t        alm_q, alm_n;
  logic              step, wbad, wr_ok, is_time, is_alarm;
  logic              tick_hit, alarm_hit, err_hit;
  logic [6:0]        wval;
  logic [7:0]        mux_data;
  field_e            wfield;

  rtc_drift_comp #(
    .COMP_W (COMP_W),
    .PERIOD (COMP_PERIOD),
    .FIRST  (COMP_FIRST)
  ) u_drift (
    .clk    (clk),
    .rst    (rst),
    .sec_in (sec_pulse && ctrl_q[0]),
    .comp   (comp_q),
    .step   (step)
  );

  rtc_cal_step u_step (
    .cur (cur_q),
    .nxt (step_t)
  );

  assign wfield = wr_en ? field_of(addr) : F_NONE;

  rtc_wr_decode u_dec (
    .field  (wfield),
    .mode12 (ctrl_q[2]),
    .wdata  (wdata),
    .value  (wval),
    .bad    (wbad)
  );

  rtc_read_mux u_mux (
    .addr (addr),
    .ctrl (ctrl_q),
    .cur  (cur_q),
    .alm  (alm_q),
    .comp (comp_q),
    .data (mux_data)
  );

  assign is_time  = (addr >= RA_SEC)  && (addr <= RA_WDAY);
  assign is_alarm = (addr >= RA_ASEC) && (addr <= RA_AYEAR);
  assign wr_ok    = wr_en && !wbad;
  assign err_hit  = wr_en && (is_time || is_alarm) && wbad;

  always_comb begin
    nxt_t = step ? step_t : cur_q;
    alm_n = alm_q;
    if (wr_ok && is_time) begin
      case (wfield)
        F_SEC:  nxt_t.sec  = wval[5:0];
        F_MIN:  nxt_t.min  = wval[5:0];
        F_HOUR: nxt_t.hour = wval[4:0];
        F_DAY:  nxt_t.day  = wval[4:0];
        F_MON:  nxt_t.mon  = wval[3:0];
        F_YEAR: nxt_t.year = wval;
        F_WDAY: nxt_t.wday = wval[2:0];
        default: ;
      endcase
    end
    if (wr_ok && is_alarm) begin
      case (wfield)
        F_SEC:  alm_n.sec  = wval[5:0];
        F_MIN:  alm_n.min  = wval[5:0];
        F_HOUR: alm_n.hour = wval[4:0];
        F_DAY:  alm_n.day  = wval[4:0];
        F_MON:  alm_n.mon  = wval[3:0];
        F_YEAR: alm_n.year = wval;
        default: ;
      endcase
    end
    case (ctrl_q[4:3])
      2'd0:    tick_hit = 1'b1;
      2'd1:    tick_hit = (nxt_t.sec == 6'd0);
      2'd2:    tick_hit = (nxt_t.sec == 6'd0) && (nxt_t.min == 6'd0);
      default: tick_hit = (nxt_t.sec == 6'd0) && (nxt_t.min == 6'd0) && (nxt_t.hour == 5'd0);
    endcase
    alarm_hit = ctrl_q[1] &&
                (nxt_t.sec  == alm_q.sec)  && (nxt_t.min == alm_q.min) &&
                (nxt_t.hour == alm_q.hour) && (nxt_t.day == alm_q.day) &&
                (nxt_t.mon  == alm_q.mon)  && (nxt_t.year == alm_q.year);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      comp_q    <= '0;
      cur_q     <= '{year: 7'd0, mon: 4'd1, day: 5'd1, wday: 3'd0,
                     hour: 5'd0, min: 6'd0, sec: 6'd0};
      alm_q     <= '{year: 7'd4, mon: 4'd1, day: 5'd1,
                     hour: 5'd0, min: 6'd0, sec: 6'd0};
      rd_data   <= '0;
      evt_tick  <= 1'b0;
      evt_alarm <= 1'b0;
      evt_err   <= 1'b0;
    end else begin
      cur_q     <= nxt_t;
      alm_q     <= alm_n;
      evt_tick  <= step && tick_hit;
      evt_alarm <= step && alarm_hit;
      evt_err   <= err_hit;
      if (wr_en) begin
        case (addr)
          RA_CTRL:    ctrl_q         <= wdata[4:0];
          RA_COMP_HI: comp_q[15:8]   <= wdata;
          RA_COMP_LO: comp_q[7:0]    <= wdata;
          default: ;
        endcase
      end
      if (rd_en) rd_data <= mux_data;
    end
  end

endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk
  import bcd_rtc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       step,
  input logic [4:0] ctrl_q,
  input rtc_time_t  cur_q,
  input rtc_alarm_t alm_q,
  input logic       evt_tick,
  input logic       evt_alarm,
  input logic       evt_err
);

  assert_field_range_R4: assert property (@(posedge clk) disable iff (rst)
    (cur_q.sec < 6'd60) && (cur_q.min < 6'd60) && (cur_q.hour < 5'd24) &&
    (cur_q.day >= 5'd1) && (cur_q.day <= 5'd31) && (cur_q.mon >= 4'd1) &&
    (cur_q.mon <= 4'd12) && (cur_q.year <= 7'd99) && (cur_q.wday <= 3'd6));

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(step) && !$past(wr_en)) |-> $stable(cur_q));

  assert_events_need_step_R3: assert property (@(posedge clk) disable iff (rst)
    (evt_tick || evt_alarm) |-> $past(step));

  assert_minute_tick_R5: assert property (@(posedge clk) disable iff (rst)
    (evt_tick && $past(ctrl_q[4:3]) == 2'd1) |-> (cur_q.sec == 6'd0));

  assert_day_tick_R5: assert property (@(posedge clk) disable iff (rst)
    (evt_tick && $past(ctrl_q[4:3]) == 2'd3) |->
      (cur_q.sec == 6'd0 && cur_q.min == 6'd0 && cur_q.hour == 5'd0));

  assert_alarm_match_R9: assert property (@(posedge clk) disable iff (rst)
    evt_alarm |-> ($past(ctrl_q[1]) &&
      cur_q.sec == $past(alm_q.sec) && cur_q.min == $past(alm_q.min) &&
      cur_q.hour == $past(alm_q.hour) && cur_q.day == $past(alm_q.day) &&
      cur_q.mon == $past(alm_q.mon) && cur_q.year == $past(alm_q.year)));

  assert_err_after_write_R10: assert property (@(posedge clk) disable iff (rst)
    evt_err |-> $past(wr_en));

endmodule

bind bcd_rtc bcd_rtc_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .step      (step),
  .ctrl_q    (ctrl_q),
  .cur_q     (cur_q),
  .alm_q     (alm_q),
  .evt_tick  (evt_tick),
  .evt_alarm (evt_alarm),
  .evt_err   (evt_err)
);

// File: tb/bcd_rtc_tb.sv
`timescale 1ns/1ps
module bcd_rtc_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_pulse = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  wire  [7:0] rd_data;
  wire        evt_tick, evt_alarm, evt_err;

  int   total = 0;
  int   bad = 0;
  int   ticks = 0;
  int   alarms = 0;
  logic err_seen = 1'b0;

  always #2.5 clk = ~clk;

  bcd_rtc u_dut (
    .clk(clk), .rst(rst), .sec_pulse(sec_pulse), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .evt_tick(evt_tick),
    .evt_alarm(evt_alarm), .evt_err(evt_err)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    err_seen = evt_err;
  endtask

  task automatic expect_reg(input string req, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    check(req, $sformatf("reg %0h", a), int'(rd_data), int'(exp));
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sec_pulse = 1'b1;
      @(negedge clk); sec_pulse = 1'b0;
      ticks += int'(evt_tick); alarms += int'(evt_alarm);
      @(negedge clk);
      ticks += int'(evt_tick); alarms += int'(evt_alarm);
    end
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                          input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
    wr(5'h05, mo); wr(5'h04, d); wr(5'h06, y);
    wr(5'h03, h);  wr(5'h02, m); wr(5'h01, s);
  endtask

  task automatic t_reset();
    check("R1", "evt_tick", int'(evt_tick), 0);
    check("R1", "evt_err", int'(evt_err), 0);
    expect_reg("R1", 5'h00, 8'h00); expect_reg("R1", 5'h01, 8'h00);
    expect_reg("R1", 5'h03, 8'h00); expect_reg("R1", 5'h04, 8'h01);
    expect_reg("R1", 5'h05, 8'h01); expect_reg("R1", 5'h06, 8'h00);
    expect_reg("R1", 5'h07, 8'h00); expect_reg("R1", 5'h0B, 8'h01);
    expect_reg("R1", 5'h0C, 8'h01); expect_reg("R1", 5'h0D, 8'h04);
    expect_reg("R1", 5'h0E, 8'h00); expect_reg("R1", 5'h0F, 8'h00);
  endtask

  task automatic t_ctrl();
    wr(5'h00, 8'hFF);
    expect_reg("R2", 5'h00, 8'h1F);
    wr(5'h00, 8'h00);
  endtask

  task automatic t_run();
    pulse(3);
    expect_reg("R3", 5'h01, 8'h00);
    wr(5'h00, 8'h01);
    pulse(5);
    expect_reg("R3", 5'h01, 8'h05);
  endtask

  task automatic t_rollover();
    set_time(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h04); wr(5'h07, 8'h06);
    pulse(1);
    expect_reg("R4", 5'h04, 8'h29); expect_reg("R4", 5'h05, 8'h02);
    expect_reg("R4", 5'h07, 8'h00); expect_reg("R4", 5'h03, 8'h00);
    expect_reg("R4", 5'h02, 8'h00); expect_reg("R4", 5'h01, 8'h00);
    set_time(8'h23, 8'h59, 8'h59, 8'h29, 8'h02, 8'h04);
    pulse(1);
    expect_reg("R4", 5'h04, 8'h01); expect_reg("R4", 5'h05, 8'h03);
    set_time(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h03);
    pulse(1);
    expect_reg("R4", 5'h04, 8'h01); expect_reg("R4", 5'h05, 8'h03);
    set_time(8'h23, 8'h59, 8'h59, 8'h30, 8'h04, 8'h10);
    pulse(1);
    expect_reg("R4", 5'h04, 8'h01); expect_reg("R4", 5'h05, 8'h05);
    set_time(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99);
    pulse(1);
    expect_reg("R4", 5'h04, 8'h01); expect_reg("R4", 5'h05, 8'h01);
    expect_reg("R4", 5'h06, 8'h00);
  endtask

  task automatic t_tick();
    wr(5'h00, 8'h01); ticks = 0; pulse(3);
    check("R5", "sel0 ticks", ticks, 3);
    wr(5'h00, 8'h09); wr(5'h02, 8'h10); wr(5'h01, 8'h58); ticks = 0; pulse(3);
    check("R5", "sel1 ticks", ticks, 1);
    wr(5'h00, 8'h11); wr(5'h03, 8'h05); wr(5'h02, 8'h59); wr(5'h01, 8'h58); ticks = 0; pulse(3);
    check("R5", "sel2 ticks", ticks, 1);
    wr(5'h00, 8'h19); wr(5'h03, 8'h23); wr(5'h02, 8'h59); wr(5'h01, 8'h58); ticks = 0; pulse(3);
    check("R5", "sel3 ticks", ticks, 1);
  endtask

  task automatic t_12h();
    wr(5'h00, 8'h04);
    wr(5'h03, 8'h92); expect_reg("R6", 5'h03, 8'h92);
    wr(5'h03, 8'h01); expect_reg("R6", 5'h03, 8'h01);
    wr(5'h00, 8'h00); expect_reg("R7", 5'h03, 8'h00);
    wr(5'h03, 8'h15); wr(5'h00, 8'h04); expect_reg("R6", 5'h03, 8'h84);
    wr(5'h03, 8'h00); check("R7", "zero AM err", int'(err_seen), 1);
    expect_reg("R7", 5'h03, 8'h84);
    wr(5'h03, 8'h80); expect_reg("R7", 5'h03, 8'h12);
    wr(5'h0A, 8'h87); wr(5'h00, 8'h00); expect_reg("R7", 5'h0A, 8'h18);
  endtask

  task automatic t_fields();
    wr(5'h00, 8'h00);
    wr(5'h01, 8'hD9); expect_reg("R8", 5'h01, 8'h59);
    wr(5'h02, 8'hA5); expect_reg("R8", 5'h02, 8'h25);
    wr(5'h05, 8'h00); expect_reg("R8", 5'h05, 8'h01);
    wr(5'h06, 8'h37); expect_reg("R8", 5'h06, 8'h37);
    wr(5'h0C, 8'h00); expect_reg("R8", 5'h0C, 8'h01);
  endtask

  task automatic t_err();
    wr(5'h01, 8'h30); check("R10", "good write err", int'(err_seen), 0);
    wr(5'h01, 8'h60); check("R10", "sec 60 err", int'(err_seen), 1);
    expect_reg("R10", 5'h01, 8'h30);
    wr(5'h01, 8'h1A); check("R10", "bad digit err", int'(err_seen), 1);
    expect_reg("R10", 5'h01, 8'h30);
    wr(5'h05, 8'h13); check("R10", "month 13 err", int'(err_seen), 1);
    expect_reg("R10", 5'h05, 8'h01);
    wr(5'h04, 8'h00); check("R10", "day 0 err", int'(err_seen), 1);
    wr(5'h07, 8'h07); check("R10", "wday 7 err", int'(err_seen), 1);
  endtask

  task automatic t_alarm();
    wr(5'h00, 8'h00);
    set_time(8'h10, 8'h20, 8'h30, 8'h05, 8'h06, 8'h07);
    wr(5'h08, 8'h32); wr(5'h09, 8'h20); wr(5'h0A, 8'h10);
    wr(5'h0B, 8'h05); wr(5'h0C, 8'h06); wr(5'h0D, 8'h07);
    wr(5'h00, 8'h03); alarms = 0; pulse(3);
    check("R9", "alarm enabled", alarms, 1);
    wr(5'h00, 8'h01); wr(5'h01, 8'h30); alarms = 0; pulse(3);
    check("R9", "alarm disabled", alarms, 0);
  endtask

  task automatic t_unmapped();
    wr(5'h00, 8'h01);
    wr(5'h1F, 8'hFF); check("R12", "unmapped err", int'(err_seen), 0);
    expect_reg("R12", 5'h00, 8'h01);
    expect_reg("R12", 5'h1F, 8'h00);
    expect_reg("R12", 5'h10, 8'h00);
  endtask

  task automatic t_comp();
    do_reset();
    wr(5'h0E, 8'h80); wr(5'h0F, 8'h00);
    expect_reg("R11", 5'h0E, 8'h80); expect_reg("R11", 5'h0F, 8'h00);
    wr(5'h00, 8'h01); pulse(1800); wr(5'h00, 8'h00);
    expect_reg("R11", 5'h02, 8'h29); expect_reg("R11", 5'h01, 8'h59);
    do_reset();
    expect_reg("R1", 5'h0E, 8'h00);
    wr(5'h0E, 8'h7F); wr(5'h0F, 8'hFF);
    wr(5'h00, 8'h01); pulse(1800);
    expect_reg("R11", 5'h02, 8'h30); expect_reg("R11", 5'h01, 8'h00);
    pulse(3600); wr(5'h00, 8'h00);
    expect_reg("R11", 5'h03, 8'h01); expect_reg("R11", 5'h02, 8'h30);
    expect_reg("R11", 5'h01, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl();
    t_run();
    t_rollover();
    t_tick();
    t_12h();
    t_fields();
    t_err();
    t_alarm();
    t_unmapped();
    t_comp();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule